// File: doc/BRIEF.md
# Wide-Bus Receive Residue Byte Handler

This block sits on the receive path between a 16-bit parallel bus and a byte-wide memory port. For each receive move it takes a command with a byte count and a chained/normal bit. It then pulls 16-bit words from the bus side and sends their bytes to memory one at a time, low byte first. The byte count always counts memory-side bytes.

A chained move that ends partway through a word does not drop the unused high byte. It keeps that byte in an internal residue register and raises a sticky residue flag. The next chained move sends the kept byte to memory first, and that byte counts as one of its own bytes. A normal move ignores the kept byte, clears the flag at its start, and drops the unused high byte of an odd-length transfer. A single-cycle done pulse marks the end of every move.

Top module: `wide_rx_residue`

## Requirements
- R1: Within each bus word, the low-order byte (bits 7:0) reaches memory before the high-order byte (bits 15:8).
- R2: A chained move whose memory-side count ends on the low byte of a word keeps bits 15:8 of that word, does not send them to memory, and raises residue_flag in the same cycle that done rises.
- R3: A chained move that starts while residue_flag is high sends the kept byte as its first memory byte, before any bus word is taken.
- R4: The total number of memory bytes always equals the command count, and the kept byte is one of them. A move takes exactly ceil(n/2) bus words, where n is the count minus one if the kept byte is used, and the full count otherwise.
- R5: A chained move that starts with residue_flag low sends the same byte sequence as a normal move with the same count and the same bus data.
- R6: A normal move with a non-zero count clears residue_flag when its command is accepted and never sends the kept byte. A normal move that ends on an odd count drops the unused high byte and leaves residue_flag low.
- R7: residue_flag falls in the cycle after the kept byte is accepted on the memory side.
- R8: done is high for exactly one cycle, in the cycle after the handshake of the last counted memory byte. At that point the block is idle.
- R9: A command with a count of zero raises done in the cycle after it is accepted. It moves no bus or memory data and leaves residue_flag and the kept byte unchanged.
- R10: cmd_ready is high only while the block is idle, and an idle block drives neither bus_ready nor mem_valid. While mem_valid is high and mem_ready is low, mem_valid and mem_data stay unchanged.
- R11: After reset, residue_flag, done, mem_valid and bus_ready are low and cmd_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Move command offered |
| cmd_ready | output | 1 | Block idle, command accepted when valid |
| cmd_chained | input | 1 | 1 = chained move, 0 = normal move |
| cmd_count | input | CNT_W | Memory-side byte count of the move |
| bus_valid | input | 1 | Bus word offered |
| bus_ready | output | 1 | Block takes the bus word |
| bus_data | input | 16 | Bus word |
| mem_valid | output | 1 | Memory byte offered |
| mem_ready | input | 1 | Memory takes the byte |
| mem_data | output | 8 | Memory byte |
| done | output | 1 | One-cycle end-of-move pulse |
| residue_flag | output | 1 | A kept high byte is waiting |

## Verification
The hardest case to reach is a chained move that both uses a kept byte and ends on a word's low byte, so that the same move consumes one residue and sets a new one. A count of one with the flag high is a related hard case, because it must send only the kept byte and take no bus word. Directed sequences lead into these cases: first an odd chained move, then chained moves of even and single counts. After that, random sequences of mixed chained and normal moves, including zero counts, run with random bus and memory stalls. A bench model tracks the flag and the kept byte, predicts every memory byte and counts the bus words.

// File: rtl/wide_rx_residue.sv
module wide_rx_residue #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_chained,
  input  logic [CNT_W-1:0] cmd_count,
  input  logic             bus_valid,
  output logic             bus_ready,
  input  logic [15:0]      bus_data,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic [7:0]       mem_data,
  output logic             done,
  output logic             residue_flag
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  typedef enum logic [2:0] {S_IDLE, S_RES, S_FETCH, S_LO, S_HI} st_t;

  st_t              st;
  logic [CNT_W-1:0] rem;
  logic [15:0]      wbuf;
  logic [7:0]       res_q;
  logic             res_v;
  logic             chn;
  logic             done_q;

  assign cmd_ready    = (st == S_IDLE);
  assign bus_ready    = (st == S_FETCH);
  assign mem_valid    = (st == S_RES) || (st == S_LO) || (st == S_HI);
  assign mem_data     = (st == S_RES) ? res_q : (st == S_HI) ? wbuf[15:8] : wbuf[7:0];
  assign done         = done_q;
  assign residue_flag = res_v;

  wire mem_hs = mem_valid && mem_ready;
  wire last   = (rem == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      rem    <= '0;
      wbuf   <= '0;
      res_q  <= '0;
      res_v  <= 1'b0;
      chn    <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (cmd_valid) begin
          chn <= cmd_chained;
          rem <= cmd_count;
          if (cmd_count == '0) begin
            done_q <= 1'b1;
          end else if (cmd_chained && res_v) begin
            st <= S_RES;
          end else begin
            if (!cmd_chained) res_v <= 1'b0;
            st <= S_FETCH;
          end
        end
        S_RES: if (mem_hs) begin
          res_v <= 1'b0;
          rem   <= rem - ONE;
          if (last) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            st <= S_FETCH;
          end
        end
        S_FETCH: if (bus_valid) begin
          wbuf <= bus_data;
          st   <= S_LO;
        end
        S_LO: if (mem_hs) begin
          rem <= rem - ONE;
          if (last) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
            if (chn) begin
              res_q <= wbuf[15:8];
              res_v <= 1'b1;
            end
          end else begin
            st <= S_HI;
          end
        end
        S_HI: if (mem_hs) begin
          rem <= rem - ONE;
          if (last) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            st <= S_FETCH;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wide_rx_residue_chk.sv
module wide_rx_residue_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             cmd_chained,
  input logic [CNT_W-1:0] cmd_count,
  input logic             bus_ready,
  input logic             mem_valid,
  input logic             mem_ready,
  input logic [7:0]       mem_data,
  input logic             done,
  input logic             residue_flag
);
  a_r2_flag_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(residue_flag) |-> done);

  a_r7_flag_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(residue_flag) |-> ($past(mem_valid && mem_ready) ||
                             $past(cmd_valid && cmd_ready && !cmd_chained)));

  a_r8_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cmd_ready && !mem_valid && !bus_ready));

  a_r9_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_count == '0) |=> (done && $stable(residue_flag)));

  a_r10_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_data)));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!bus_ready && !mem_valid));
endmodule

bind wide_rx_residue wide_rx_residue_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_chained(cmd_chained), .cmd_count(cmd_count), .bus_ready(bus_ready),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_data(mem_data),
  .done(done), .residue_flag(residue_flag)
);

// File: tb/wide_rx_residue_tb.sv
module wide_rx_residue_tb;
  localparam int CNT_W = 16;
  localparam int MAXC  = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_chained = 1'b0;
  logic [CNT_W-1:0] cmd_count = '0;
  logic bus_valid = 1'b0, mem_ready = 1'b0;
  logic [15:0] bus_data = '0;
  logic cmd_ready, bus_ready, mem_valid, done, residue_flag;
  logic [7:0] mem_data;

  int checks = 0, failures = 0;
  bit ended = 0;

  bit       m_flag = 0;
  logic [7:0] m_res = '0;
  logic [15:0] words [0:MAXC];
  logic [7:0]  expb  [0:MAXC];

  always #10 clk = ~clk;

  wide_rx_residue #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_chained(cmd_chained), .cmd_count(cmd_count), .bus_valid(bus_valid),
    .bus_ready(bus_ready), .bus_data(bus_data), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_data(mem_data), .done(done),
    .residue_flag(residue_flag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int words_needed(input bit ch, input int cnt, input bit flag);
    int n = (ch && flag && cnt > 0) ? cnt - 1 : cnt;
    return (n + 1) / 2;
  endfunction

  task automatic run_move(input bit ch, input int cnt, input string tag);
    int n, k, got, wi, nw, base, guard;
    bit use_res, fin, prev_stall;
    logic [7:0] prev_d;
    for (int i = 0; i <= MAXC; i++) words[i] = 16'($urandom);
    use_res = ch && m_flag && cnt > 0;
    n = use_res ? cnt - 1 : cnt;
    nw = words_needed(ch, cnt, m_flag);
    k = 0;
    if (use_res) begin expb[0] = m_res; k = 1; end
    for (int j = 0; j < n; j++) expb[k + j] = j[0] ? words[j/2][15:8] : words[j/2][7:0];
    base = k;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_chained = ch; cmd_count = CNT_W'(cnt);
    bus_valid = 1'b0; mem_ready = 1'b0;
    #1 chk(cmd_ready === 1'b1, "R10 cmd_ready idle", cmd_ready, 1);
    got = 0; wi = 0; fin = (cnt == 0); prev_stall = 0; prev_d = '0; guard = 0;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (cnt > 0 && !ch) chk(residue_flag === 1'b0, {"R6 flag cleared at start ", tag}, residue_flag, 0);
    while (guard < 400) begin
      guard++;
      if (fin) begin
        chk(done === 1'b1, {"R8/R9 done pulse ", tag}, done, 1);
        break;
      end
      if (done !== 1'b0) chk(0, {"R8 early done ", tag}, done, 0);
      bus_valid = ($urandom % 4) != 0;
      bus_data  = words[wi];
      mem_ready = ($urandom % 3) != 0;
      #1;
      if (prev_stall) chk(mem_valid && mem_data == prev_d, "R10 stall hold", mem_data, prev_d);
      prev_stall = mem_valid && !mem_ready;
      prev_d = mem_data;
      if (use_res && got == 0 && wi != 0) chk(0, "R3 bus word before residue", wi, 0);
      if (bus_valid && bus_ready) wi++;
      if (mem_valid && mem_ready) begin
        if (got < cnt)
          chk(mem_data === expb[got],
              (use_res && got == 0) ? {"R3 residue first ", tag} :
              (ch ? {"R1/R5 byte order ", tag} : {"R1/R6 byte order ", tag}),
              mem_data, expb[got]);
        else chk(0, "R4 extra byte", got, cnt);
        got++;
        if (got == cnt) fin = 1;
      end
      @(negedge clk);
      bus_valid = 1'b0; mem_ready = 1'b0;
    end
    if (!fin) chk(0, {"R8 move hung ", tag}, got, cnt);
    #1;
    chk(wi == nw, {"R4 bus words ", tag}, wi, nw);
    @(negedge clk);
    chk(done === 1'b0, "R8 single-cycle done", done, 0);
    if (cnt > 0) begin
      if (use_res) m_flag = 0;
      if (!ch) m_flag = 0;
      if (ch && n[0]) begin m_flag = 1; m_res = words[nw - 1][15:8]; end
    end
    chk(residue_flag === m_flag, {"R2/R6/R7/R9 flag after ", tag}, residue_flag, m_flag);
    if (base < 0) chk(0, "unused", 0, 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!ended) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(residue_flag === 0 && done === 0 && mem_valid === 0 && bus_ready === 0 && cmd_ready === 1,
        "R11 reset state", {residue_flag, done, mem_valid, bus_ready, cmd_ready}, 5'b00001);
    run_move(1, 5, "chained odd");
    run_move(0, 0, "zero with flag");
    run_move(1, 4, "chained residue then odd");
    run_move(1, 1, "chained single residue");
    run_move(1, 6, "chained even no flag");
    run_move(1, 3, "chained odd again");
    run_move(0, 4, "normal ignores residue");
    run_move(0, 3, "normal odd");
    run_move(1, 2, "chained after normal");
    for (int i = 0; i < 60; i++)
      run_move(1'($urandom), int'($urandom % 21), "random");
    ended = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule